// File: doc/BRIEF.md
# Register Rename Stage with Free List and Rollback

This block sits between decode and dispatch in an out-of-order core whose integer and floating-point registers share one physical register file. It accepts at most one instruction per cycle through a ready/valid handshake. Each instruction names up to two architectural sources and an optional architectural destination, all drawn from a single architectural index space. Indices below 32 are the integer file and indices from 32 up are the floating-point file. The sources are looked up in a mapping table. A destination receives a fresh physical register from the head of a free-list FIFO. The destination's previous mapping is recorded as the stale register, and the table is then updated. The renamed tuple (new destination, stale destination, two physical sources) and a reorder-buffer slot tag leave the stage one cycle later, once the entry has been written into the reorder buffer.

The block keeps the bookkeeping that a unified register file needs. When the core retires the oldest instruction, its stale register goes back to the free list. When an exception flushes the machine, the block walks the reorder buffer from the youngest entry to the oldest, one entry per cycle. For each entry it puts the stale mapping back into the table and returns the discarded physical register to the free list. New instructions and commits are held off until the walk finishes.

Top module: `rename_stage`

## Requirements
- R1: An instruction is accepted in a cycle where `in_valid` and `in_ready` are both high. Its renamed result appears with `out_valid` high for exactly one cycle, in the following cycle. At most one instruction is accepted per cycle.
- R2: `out_pr1` and `out_pr2` are the mappings of the two sources as they stood before the instruction's own destination update. An instruction that reads and writes the same register therefore sees the older mapping.
- R3: After reset, architectural register i maps to physical register i. The free list holds physical registers ARCH_REGS to PHYS_REGS-1 in ascending order. Each new destination is taken from the free-list head in FIFO order.
- R4: `out_lprd` is the mapping the destination held just before the rename. Every later instruction that reads that register gets `out_prd`.
- R5: An instruction with `in_has_dst` low takes nothing from the free list and leaves the table unchanged. Its result has `out_dst_valid` low and both `out_prd` and `out_lprd` equal to 0.
- R6: `out_tag` is the reorder-buffer slot index. It starts at 0 after reset and advances by one per accepted instruction, modulo ROB_SLOTS. After a rollback, allocation resumes at the slot of the oldest discarded entry.
- R7: A `commit_req` pulse retires the oldest reorder-buffer entry and, if that entry had a destination, appends its stale register to the free-list tail. A commit request is ignored when the reorder buffer is empty, while `flush_req` is high, and during recovery.
- R8: `in_ready` is low in four cases: the instruction has a destination and the free list is empty; the reorder buffer is full; `flush_req` is high; or `recovering` is high. An instruction without a destination is still accepted when only the free list is empty.
- R9: A `flush_req` pulse raises `recovering` in the next cycle. The block then removes entries from youngest to oldest, one per cycle. Each removed entry with a destination restores that destination's mapping to its stale register and appends its new register to the free-list tail. `recovering` falls after the reorder buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The stage can accept the offered instruction |
| in_src1 | input | $clog2(ARCH_REGS) | First architectural source |
| in_src2 | input | $clog2(ARCH_REGS) | Second architectural source |
| in_has_dst | input | 1 | The instruction writes a destination |
| in_dst | input | $clog2(ARCH_REGS) | Architectural destination |
| commit_req | input | 1 | Retire the oldest reorder-buffer entry |
| flush_req | input | 1 | Exception: roll back all in-flight entries |
| recovering | output | 1 | Rollback walk in progress |
| out_valid | output | 1 | Renamed result valid this cycle |
| out_dst_valid | output | 1 | Result carries a destination |
| out_prd | output | $clog2(PHYS_REGS) | New physical destination |
| out_lprd | output | $clog2(PHYS_REGS) | Previous physical mapping of the destination |
| out_pr1 | output | $clog2(PHYS_REGS) | Physical first source |
| out_pr2 | output | $clog2(PHYS_REGS) | Physical second source |
| out_tag | output | $clog2(ROB_SLOTS) | Reorder-buffer slot of the instruction |

## Verification
The assertions watch the invariants every cycle. The free list is never popped when empty or pushed when full. The reorder buffer is never allocated when full, and a retire and a rollback pop never fall in the same cycle. The mapping table never sees a rename write and a restore write together. A renamed destination always differs from its stale register, and a result without a destination carries zero specifiers. Only the bench's scenarios can show the values themselves: the source lookup before the destination update, the FIFO order of reused registers, the tag wrap, the stall release after a commit, and the map contents and free-list order after a rollback. The bench shows these by comparing every renamed tuple against its own model.

// File: rtl/rn_pkg.sv
package rn_pkg;

  localparam int unsigned DEF_ARCH_REGS = 64;
  localparam int unsigned DEF_PHYS_REGS = 72;
  localparam int unsigned DEF_ROB_SLOTS = 16;

  // Circular index arithmetic shared by the free list and reorder buffer.
  function automatic int unsigned ring_up(input int unsigned idx, input int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  function automatic int unsigned ring_down(input int unsigned idx, input int unsigned depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction

  // Admission rule of the rename stage.
  function automatic logic rename_admit(input logic busy, input logic flush,
                                        input logic rob_full, input logic fl_empty,
                                        input logic needs_dst);
    return !busy && !flush && !rob_full && !(needs_dst && fl_empty);
  endfunction

endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int unsigned PHYS_W    = 7,
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned FIRST_REG = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push,
  input  logic [PHYS_W-1:0] push_reg,
  output logic [PHYS_W-1:0] head_reg,
  output logic              empty,
  output logic              full
);
  localparam int unsigned PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);

  logic [PHYS_W-1:0] slot_q [SLOTS];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_W'(SLOTS));
  assign head_reg = slot_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SLOTS); i++) slot_q[i] <= PHYS_W'(FIRST_REG + i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CNT_W'(SLOTS);
    end else begin
      if (push) begin
        slot_q[wr_q] <= push_reg;
        wr_q <= PTR_W'(rn_pkg::ring_up(32'(wr_q), SLOTS));
      end
      if (pop) rd_q <= PTR_W'(rn_pkg::ring_up(32'(rd_q), SLOTS));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_pop_has_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_push_has_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
  parameter int unsigned ARCH_N = 64,
  parameter int unsigned ARCH_W = 6,
  parameter int unsigned PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] src_a,
  input  logic [ARCH_W-1:0] src_b,
  input  logic [ARCH_W-1:0] dst,
  output logic [PHYS_W-1:0] map_a,
  output logic [PHYS_W-1:0] map_b,
  output logic [PHYS_W-1:0] map_dst,
  input  logic              ren_we,
  input  logic [ARCH_W-1:0] ren_idx,
  input  logic [PHYS_W-1:0] ren_val,
  input  logic              undo_we,
  input  logic [ARCH_W-1:0] undo_idx,
  input  logic [PHYS_W-1:0] undo_val
);
  logic [PHYS_W-1:0] map_q [ARCH_N];

  // Lookups see the table before this cycle's write lands.
  assign map_a   = map_q[src_a];
  assign map_b   = map_q[src_b];
  assign map_dst = map_q[dst];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(ARCH_N); i++) map_q[i] <= PHYS_W'(i);
    end else if (ren_we) begin
      map_q[ren_idx] <= ren_val;
    end else if (undo_we) begin
      map_q[undo_idx] <= undo_val;
    end
  end

  assert_single_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ren_we && undo_we));

endmodule

// File: rtl/rn_rob.sv
module rn_rob #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned ARCH_W = 6,
  parameter int unsigned PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              alloc_dv,
  input  logic [ARCH_W-1:0] alloc_rd,
  input  logic [PHYS_W-1:0] alloc_prd,
  input  logic [PHYS_W-1:0] alloc_lprd,
  input  logic              retire,
  input  logic              unwind,
  output logic [TAG_W-1:0]  tail_tag,
  output logic              full,
  output logic              empty,
  output logic              old_dv,
  output logic [PHYS_W-1:0] old_lprd,
  output logic              young_dv,
  output logic [ARCH_W-1:0] young_rd,
  output logic [PHYS_W-1:0] young_prd,
  output logic [PHYS_W-1:0] young_lprd
);
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);

  typedef struct packed {
    logic              dv;
    logic [ARCH_W-1:0] rd;
    logic [PHYS_W-1:0] prd;
    logic [PHYS_W-1:0] lprd;
  } rob_entry_t;

  rob_entry_t       ent_q [SLOTS];
  logic [TAG_W-1:0] head_q, tail_q, young_idx;
  logic [CNT_W-1:0] cnt_q;

  assign young_idx  = TAG_W'(rn_pkg::ring_down(32'(tail_q), SLOTS));
  assign tail_tag   = tail_q;
  assign full       = (cnt_q == CNT_W'(SLOTS));
  assign empty      = (cnt_q == '0);
  assign old_dv     = ent_q[head_q].dv;
  assign old_lprd   = ent_q[head_q].lprd;
  assign young_dv   = ent_q[young_idx].dv;
  assign young_rd   = ent_q[young_idx].rd;
  assign young_prd  = ent_q[young_idx].prd;
  assign young_lprd = ent_q[young_idx].lprd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SLOTS); i++) ent_q[i] <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc) begin
        ent_q[tail_q] <= '{dv: alloc_dv, rd: alloc_rd, prd: alloc_prd, lprd: alloc_lprd};
        tail_q <= TAG_W'(rn_pkg::ring_up(32'(tail_q), SLOTS));
      end else if (unwind) begin
        tail_q <= young_idx;
      end
      if (retire) head_q <= TAG_W'(rn_pkg::ring_up(32'(head_q), SLOTS));
      case ({alloc, retire || unwind})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_alloc_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);

  assert_pop_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire && unwind));

  assert_unwind_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unwind |-> !empty);

  assert_no_alloc_in_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc && unwind));

endmodule

// File: rtl/rename_stage.sv
module rename_stage
  import rn_pkg::*;
#(
  parameter int unsigned ARCH_REGS = DEF_ARCH_REGS,
  parameter int unsigned PHYS_REGS = DEF_PHYS_REGS,
  parameter int unsigned ROB_SLOTS = DEF_ROB_SLOTS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [$clog2(ARCH_REGS)-1:0] in_src1,
  input  logic [$clog2(ARCH_REGS)-1:0] in_src2,
  input  logic                         in_has_dst,
  input  logic [$clog2(ARCH_REGS)-1:0] in_dst,
  input  logic                         commit_req,
  input  logic                         flush_req,
  output logic                         recovering,
  output logic                         out_valid,
  output logic                         out_dst_valid,
  output logic [$clog2(PHYS_REGS)-1:0] out_prd,
  output logic [$clog2(PHYS_REGS)-1:0] out_lprd,
  output logic [$clog2(PHYS_REGS)-1:0] out_pr1,
  output logic [$clog2(PHYS_REGS)-1:0] out_pr2,
  output logic [$clog2(ROB_SLOTS)-1:0] out_tag
);
  localparam int unsigned ARCH_W   = $clog2(ARCH_REGS);
  localparam int unsigned PHYS_W   = $clog2(PHYS_REGS);
  localparam int unsigned TAG_W    = $clog2(ROB_SLOTS);
  localparam int unsigned FL_SLOTS = PHYS_REGS - ARCH_REGS;

  // Named internal events.
  logic              fire, take_reg, retire_do, unwind_do, fl_push;
  logic [PHYS_W-1:0] fl_push_reg, fl_head, new_prd, new_lprd;
  logic              fl_empty, fl_full;
  logic [TAG_W-1:0]  rob_tail;
  logic              rob_full, rob_empty;
  logic              old_dv, young_dv;
  logic [PHYS_W-1:0] old_lprd, young_prd, young_lprd;
  logic [ARCH_W-1:0] young_rd;
  logic [PHYS_W-1:0] map_a, map_b, map_dst;
  logic              recover_q;

  assign recovering  = recover_q;
  assign in_ready    = rename_admit(recover_q, flush_req, rob_full, fl_empty, in_has_dst);
  assign fire        = in_valid && in_ready;
  assign take_reg    = fire && in_has_dst;
  assign retire_do   = commit_req && !flush_req && !recover_q && !rob_empty;
  assign unwind_do   = recover_q && !rob_empty;
  assign fl_push     = (retire_do && old_dv) || (unwind_do && young_dv);
  assign fl_push_reg = unwind_do ? young_prd : old_lprd;
  assign new_prd     = take_reg ? fl_head : '0;
  assign new_lprd    = take_reg ? map_dst : '0;

  rn_freelist #(
    .PHYS_W(PHYS_W), .SLOTS(FL_SLOTS), .FIRST_REG(ARCH_REGS)
  ) u_freelist (
    .clk(clk), .rst_n(rst_n), .pop(take_reg), .push(fl_push),
    .push_reg(fl_push_reg), .head_reg(fl_head), .empty(fl_empty), .full(fl_full)
  );

  rn_maptable #(
    .ARCH_N(ARCH_REGS), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .src_a(in_src1), .src_b(in_src2), .dst(in_dst),
    .map_a(map_a), .map_b(map_b), .map_dst(map_dst),
    .ren_we(take_reg), .ren_idx(in_dst), .ren_val(fl_head),
    .undo_we(unwind_do && young_dv), .undo_idx(young_rd), .undo_val(young_lprd)
  );

  rn_rob #(
    .SLOTS(ROB_SLOTS), .TAG_W(TAG_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
  ) u_rob (
    .clk(clk), .rst_n(rst_n),
    .alloc(fire), .alloc_dv(in_has_dst), .alloc_rd(in_dst),
    .alloc_prd(new_prd), .alloc_lprd(new_lprd),
    .retire(retire_do), .unwind(unwind_do),
    .tail_tag(rob_tail), .full(rob_full), .empty(rob_empty),
    .old_dv(old_dv), .old_lprd(old_lprd),
    .young_dv(young_dv), .young_rd(young_rd), .young_prd(young_prd),
    .young_lprd(young_lprd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      recover_q <= 1'b0;
    else if (flush_req)              recover_q <= 1'b1;
    else if (recover_q && rob_empty) recover_q <= 1'b0;
  end

  // Renamed tuple leaves once the entry is in the reorder buffer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_dst_valid <= 1'b0;
      out_prd       <= '0;
      out_lprd      <= '0;
      out_pr1       <= '0;
      out_pr2       <= '0;
      out_tag       <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_dst_valid <= in_has_dst;
        out_prd       <= new_prd;
        out_lprd      <= new_lprd;
        out_pr1       <= map_a;
        out_pr2       <= map_b;
        out_tag       <= rob_tail;
      end
    end
  end

  assert_fresh_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dst_valid) |-> (out_prd != out_lprd));

  assert_nodst_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dst_valid) |-> (out_prd == '0 && out_lprd == '0));

  assert_walk_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> !in_ready);

  assert_flush_starts_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> recovering);

endmodule

// File: tb/rename_stage_test.sv
`timescale 1ns/1ps
module rename_stage_test;
  localparam int AR = 64;
  localparam int PR = 72;
  localparam int RS = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_has_dst, commit_req, flush_req, recovering;
  logic [5:0] in_src1, in_src2, in_dst;
  logic       out_valid, out_dst_valid;
  logic [6:0] out_prd, out_lprd, out_pr1, out_pr2;
  logic [3:0] out_tag;

  always #5 clk = ~clk;

  rename_stage #(.ARCH_REGS(AR), .PHYS_REGS(PR), .ROB_SLOTS(RS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src1(in_src1), .in_src2(in_src2), .in_has_dst(in_has_dst), .in_dst(in_dst),
    .commit_req(commit_req), .flush_req(flush_req), .recovering(recovering),
    .out_valid(out_valid), .out_dst_valid(out_dst_valid), .out_prd(out_prd),
    .out_lprd(out_lprd), .out_pr1(out_pr1), .out_pr2(out_pr2), .out_tag(out_tag)
  );

  typedef struct {bit dv; int rd; int prd; int lprd;} rob_m_t;
  typedef struct {bit dv; int prd; int lprd; int pr1; int pr2; int tag;} exp_t;

  int     checks = 0;
  int     bad = 0;
  bit     finished = 0;
  string  phase = "reset";
  int     map_m [AR];
  int     fl_q [$];
  rob_m_t rob_q [$];
  exp_t   exp_q [$];
  int     tail_m = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s [%s] act=%0d exp=%0d", req, what, phase, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a renamed tuple comes out.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; bad++;
        $display("FAIL R1 unexpected out_valid [%s] act=1 exp=0", phase);
      end else begin
        e = exp_q.pop_front();
        chk("R2", "pr1", int'(out_pr1), e.pr1);
        chk("R2", "pr2", int'(out_pr2), e.pr2);
        chk("R5", "dst_valid", int'(out_dst_valid), int'(e.dv));
        chk("R3", "prd", int'(out_prd), e.prd);
        chk("R4", "lprd", int'(out_lprd), e.lprd);
        chk("R6", "tag", int'(out_tag), e.tag);
      end
    end
  end

  // Driver: called at a negedge; keeps offering until accepted.
  task automatic do_rename(int s1, int s2, bit hd, int d);
    exp_t e;
    in_valid = 1'b1; in_src1 = 6'(s1); in_src2 = 6'(s2);
    in_has_dst = hd; in_dst = 6'(d);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    e.pr1 = map_m[s1];
    e.pr2 = map_m[s2];
    e.dv  = hd;
    if (hd) begin
      e.prd = fl_q.pop_front();
      e.lprd = map_m[d];
      map_m[d] = e.prd;
    end else begin
      e.prd = 0; e.lprd = 0;
    end
    e.tag = tail_m;
    tail_m = (tail_m + 1) % RS;
    rob_q.push_back('{hd, d, e.prd, e.lprd});
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_commit();
    rob_m_t r;
    commit_req = 1'b1;
    if (rob_q.size() > 0) begin
      r = rob_q.pop_front();
      if (r.dv) fl_q.push_back(r.lprd);
    end
    @(negedge clk);
    commit_req = 1'b0;
  endtask

  task automatic do_flush();
    rob_m_t r;
    flush_req = 1'b1;
    while (rob_q.size() > 0) begin
      r = rob_q.pop_back();
      if (r.dv) begin
        map_m[r.rd] = r.lprd;
        fl_q.push_back(r.prd);
      end
      tail_m = (tail_m + RS - 1) % RS;
    end
    @(negedge clk);
    flush_req = 1'b0;
    #1;
    chk("R9", "recovering after flush", int'(recovering), 1);
    chk("R8", "in_ready while recovering", int'(in_ready), 0);
    while (recovering) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < AR; i++) map_m[i] = i;
    for (int p = AR; p < PR; p++) fl_q.push_back(p);
    rst_n = 1'b0; in_valid = 1'b0; in_has_dst = 1'b0; commit_req = 1'b0; flush_req = 1'b0;
    in_src1 = '0; in_src2 = '0; in_dst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "in_ready after reset", int'(in_ready), 1);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R9", "recovering after reset", int'(recovering), 0);

    // R2 R4: f0 = f0 + f1 reads the old f0, then the next reader sees the new one.
    phase = "R2 dependent chain";
    do_rename(32, 33, 1, 32);
    do_rename(32, 0, 1, 1);
    phase = "R5 store";
    do_rename(2, 32, 0, 0);
    phase = "R3 drain free list";
    for (int k = 3; k <= 8; k++) do_rename(k - 1, k, 1, k);

    // R8: free list empty blocks a writer but not a store.
    phase = "R8 free list empty";
    in_valid = 1'b1; in_has_dst = 1'b1; in_dst = 6'd9; #1;
    chk("R8", "ready with dst and empty free list", int'(in_ready), 0);
    @(negedge clk);
    in_has_dst = 1'b0; #1;
    chk("R8", "ready for store with empty free list", int'(in_ready), 1);
    in_valid = 1'b0;
    do_rename(4, 5, 0, 0);

    // R7: commit returns the stale f0 register; it is the next one handed out.
    phase = "R7 commit reuse";
    do_commit();
    do_rename(32, 1, 1, 10);

    // R6 R8: fill the reorder buffer, tags wrap past the last slot.
    phase = "R6 fill rob";
    for (int k = 0; k < 6; k++) do_rename(k, k + 1, 0, 0);
    phase = "R8 rob full";
    in_valid = 1'b1; in_has_dst = 1'b0; #1;
    chk("R8", "ready with full rob", int'(in_ready), 0);
    in_valid = 1'b0;
    do_commit();
    #1;
    chk("R8", "ready after commit frees a slot", int'(in_ready), 1);
    do_rename(1, 32, 0, 0);

    // R9: roll back everything in flight.
    phase = "R9 rollback";
    do_flush();
    phase = "R7 commit on empty rob";
    do_commit();
    phase = "R9 restored map";
    do_rename(32, 1, 1, 3);
    do_rename(8, 10, 1, 32);
    do_rename(3, 32, 1, 5);

    repeat (3) @(negedge clk);
    chk("R1", "outstanding results", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; bad++;
      $display("FAIL R1 watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule